// File: doc/BRIEF.md
# Aliased-Register Interrupt Collector

This block collects level-sensitive interrupt sources and drives one interrupt request line toward a processor. Every source that is seen high for a clock edge is latched as pending. Each source has an enable bit and a two-bit priority field in a packed control word, with four sources sharing each word. A global enable gates the whole request line. Among the pending and enabled sources, the lowest-numbered one is the winner, and a status register reports its number.

Software reads the status register, then writes that number to the vector register. This places the collector in service and holds the request line low. A later write to the level-acknowledge register releases the collector so that it can present the next source. Latched pending state is dropped through a separate bank of clear words, one bit per source.

Every register occupies a 16-byte slot with four word aliases. The alias is selected by address bits [3:2]: 0 is a plain write, 1 ORs the data in, 2 clears the bits that are written as 1, and 3 toggles them. Reads have one cycle of latency on a simple 32-bit bus.

Top module: `irq_collector`

## Requirements
- R1: After synchronous reset, irq_out is 0, the global enable (0x020) reads 0, every control word reads 0, and the status register reads 0.
- R2: A write to a register slot applies the alias given by address bits [3:2]: 0 replaces the contents with the data, 1 ORs the data in, 2 clears the bits set in the data, and 3 toggles the bits set in the data.
- R3: Control word k is at byte 0x100+0x10*k. Source n uses word n/4, field bits [8*(n%4)+7 : 8*(n%4)], with enable at field bit 2 and priority at field bits [1:0]. Only those three bits of each field are stored, so the mask 0x07070707 applies and all other bits read 0.
- R4: A source that is high at a clock edge becomes pending. Clear word j at byte 0x200+0x10*j reads the pending bits of sources 32j..32j+31, one bit per source. Writing 1 to a bit through any alias drops that source's pending state. The write has no effect while the source is still high.
- R5: The status register at 0x030 returns the number of the lowest-numbered source that is both pending and enabled in bits [5:0], with bit 31 set to 1. When no such source exists, it reads 0. Pending sources that are masked are ignored.
- R6: irq_out is registered. It is 1 in the cycle after a state in which the global enable is set, at least one enabled source is pending, and the collector is not in service.
- R7: The global enable is bit 0 of the register at 0x020. While it is 0, irq_out stays 0.
- R8: Any write to the vector register at 0x000 stores the aliased value, which reads back, and places the collector in service. irq_out is then 0 from the next cycle.
- R9: A write to the level-acknowledge register at 0x010 with data bit 0 set ends the in-service state. A write there with bit 0 clear has no effect, and the register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| src_in | input | NUM_SRC | Level interrupt sources |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
A register write takes effect at the edge that samples it. Read data for a read strobe sampled at edge k is visible after edge k. The monitor therefore compares each queued expected read value shortly after the edge that sampled the strobe. A source pulse becomes pending at the edge that sees it high, and irq_out follows one edge later, because it is computed from that registered state. For this reason, every request-line check waits one further cycle after a write or a source pulse before sampling at the falling edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_TOG   = 2'd3
  } alias_op_e;

  function automatic logic [31:0] apply_alias(input alias_op_e op,
                                              input logic [31:0] old_v,
                                              input logic [31:0] wd);
    case (op)
      OP_SET:  apply_alias = old_v | wd;
      OP_CLR:  apply_alias = old_v & ~wd;
      OP_TOG:  apply_alias = old_v ^ wd;
      default: apply_alias = wd;
    endcase
  endfunction
endpackage

// File: rtl/irqc_ctrl_bank.sv
module irqc_ctrl_bank
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  localparam int NUM_CW = NUM_SRC / 4,
  localparam int CW_IW  = (NUM_CW > 1) ? $clog2(NUM_CW) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CW_IW-1:0]  wr_idx,
  input  alias_op_e         wr_op,
  input  logic [31:0]       wr_data,
  input  logic [CW_IW-1:0]  rd_idx,
  output logic [31:0]       rd_word,
  output logic [NUM_SRC-1:0] en_vec
);
  localparam logic [31:0] FIELD_MASK = 32'h0707_0707;

  logic [31:0] cw_q [NUM_CW];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_CW; k++) cw_q[k] <= '0;
    end else if (wr_en) begin
      cw_q[wr_idx] <= apply_alias(wr_op, cw_q[wr_idx], wr_data) & FIELD_MASK;
    end
  end

  assign rd_word = cw_q[rd_idx];

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_en
    assign en_vec[n] = cw_q[n / 4][8 * (n % 4) + 2];
  end
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending #(
  parameter int NUM_SRC = 64,
  localparam int NUM_PW = (NUM_SRC + 31) / 32,
  localparam int PW_IW  = (NUM_PW > 1) ? $clog2(NUM_PW) : 1,
  localparam int PAD    = NUM_PW * 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               clr_en,
  input  logic [PW_IW-1:0]   clr_idx,
  input  logic [31:0]        clr_bits,
  input  logic [PW_IW-1:0]   rd_idx,
  output logic [31:0]        rd_word,
  output logic [NUM_SRC-1:0] pend
);
  logic [PAD-1:0] pend_q;
  logic [PAD-1:0] src_pad;
  logic [PAD-1:0] clr_mask;

  always_comb begin
    src_pad = '0;
    src_pad[NUM_SRC-1:0] = src_in;
    clr_mask = '0;
    if (clr_en) clr_mask[clr_idx*32 +: 32] = clr_bits;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_mask) | src_pad;
  end

  assign rd_word = pend_q[rd_idx*32 +: 32];
  assign pend    = pend_q[NUM_SRC-1:0];
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int NUM_SRC = 64,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] req,
  output logic               win_valid,
  output logic [IDX_W-1:0]   win_idx
);
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_collector.sv
module irq_collector
  import irqc_pkg::*;
#(
  parameter int NUM_SRC   = 64,
  parameter int ADDR_W    = 12,
  parameter int CTRL_SLOT = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_SRC-1:0] src_in,
  output logic               irq_out
);
  localparam int NUM_CW   = NUM_SRC / 4;
  localparam int NUM_PW   = (NUM_SRC + 31) / 32;
  localparam int CW_IW    = (NUM_CW > 1) ? $clog2(NUM_CW) : 1;
  localparam int PW_IW    = (NUM_PW > 1) ? $clog2(NUM_PW) : 1;
  localparam int IDX_W    = $clog2(NUM_SRC);
  localparam int SLOT_W   = ADDR_W - 4;
  localparam int CLR_SLOT = CTRL_SLOT + NUM_CW;

  logic [SLOT_W-1:0] slot;
  alias_op_e         op;
  logic              sel_vec, sel_ack, sel_glb, sel_stat, sel_cw, sel_pw;
  logic [CW_IW-1:0]  cw_idx;
  logic [PW_IW-1:0]  pw_idx;
  logic              vec_hit, ack_hit;

  logic               gen_en;
  logic               in_service;
  logic [31:0]        vec_q;
  logic [31:0]        cw_rd, pw_rd;
  logic [NUM_SRC-1:0] en_vec, pend;
  logic               win_valid;
  logic [IDX_W-1:0]   win_idx;

  assign slot     = bus_addr[ADDR_W-1:4];
  assign op       = alias_op_e'(bus_addr[3:2]);
  assign sel_vec  = (slot == SLOT_W'(0));
  assign sel_ack  = (slot == SLOT_W'(1));
  assign sel_glb  = (slot == SLOT_W'(2));
  assign sel_stat = (slot == SLOT_W'(3));
  assign sel_cw   = (slot >= SLOT_W'(CTRL_SLOT)) && (slot < SLOT_W'(CLR_SLOT));
  assign sel_pw   = (slot >= SLOT_W'(CLR_SLOT)) && (slot < SLOT_W'(CLR_SLOT + NUM_PW));
  assign cw_idx   = CW_IW'(slot - SLOT_W'(CTRL_SLOT));
  assign pw_idx   = PW_IW'(slot - SLOT_W'(CLR_SLOT));
  assign vec_hit  = bus_wr && sel_vec;
  assign ack_hit  = bus_wr && sel_ack && bus_wdata[0];

  irqc_ctrl_bank #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bus_wr && sel_cw),
    .wr_idx  (cw_idx),
    .wr_op   (op),
    .wr_data (bus_wdata),
    .rd_idx  (cw_idx),
    .rd_word (cw_rd),
    .en_vec  (en_vec)
  );

  irqc_pending #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .src_in   (src_in),
    .clr_en   (bus_wr && sel_pw),
    .clr_idx  (pw_idx),
    .clr_bits (bus_wdata),
    .rd_idx   (pw_idx),
    .rd_word  (pw_rd),
    .pend     (pend)
  );

  irqc_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .req       (pend & en_vec),
    .win_valid (win_valid),
    .win_idx   (win_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_en     <= 1'b0;
      vec_q      <= '0;
      in_service <= 1'b0;
      irq_out    <= 1'b0;
    end else begin
      if (bus_wr && sel_glb) begin
        gen_en <= apply_alias(op, {31'b0, gen_en}, bus_wdata)[0];
      end
      if (vec_hit) begin
        vec_q <= apply_alias(op, vec_q, bus_wdata);
      end
      if (vec_hit)      in_service <= 1'b1;
      else if (ack_hit) in_service <= 1'b0;
      irq_out <= gen_en && (|(pend & en_vec)) && !in_service;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (sel_vec)       bus_rdata <= vec_q;
      else if (sel_glb)  bus_rdata <= {31'b0, gen_en};
      else if (sel_stat) bus_rdata <= win_valid ? {1'b1, {(31-IDX_W){1'b0}}, win_idx} : 32'b0;
      else if (sel_cw)   bus_rdata <= cw_rd;
      else if (sel_pw)   bus_rdata <= pw_rd;
      else               bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int NUM_SRC = 64,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] src_in,
  input logic               irq_out,
  input logic               gen_en,
  input logic               in_service,
  input logic [NUM_SRC-1:0] pend,
  input logic [NUM_SRC-1:0] en_vec,
  input logic               win_valid,
  input logic [IDX_W-1:0]   win_idx,
  input logic               vec_hit,
  input logic               ack_hit
);
  // R7
  property glb_off_p;
    @(posedge clk) disable iff (rst) !gen_en |=> !irq_out;
  endproperty
  glb_off_quiet_chk: assert property (glb_off_p);

  // R8
  property busy_p;
    @(posedge clk) disable iff (rst) in_service |=> !irq_out;
  endproperty
  busy_quiet_chk: assert property (busy_p);

  // R4
  property latch_p;
    @(posedge clk) disable iff (rst)
      (src_in != '0) |=> ((pend & $past(src_in)) == $past(src_in));
  endproperty
  pend_latch_chk: assert property (latch_p);

  // R5
  property win_p;
    @(posedge clk) disable iff (rst)
      win_valid |-> (pend[win_idx] && en_vec[win_idx] &&
                     (((pend & en_vec) & ((NUM_SRC'(1) << win_idx) - NUM_SRC'(1))) == '0));
  endproperty
  win_lowest_chk: assert property (win_p);

  // R9
  property ack_p;
    @(posedge clk) disable iff (rst) (ack_hit && !vec_hit) |=> !in_service;
  endproperty
  ack_release_chk: assert property (ack_p);

  // R8
  property vec_p;
    @(posedge clk) disable iff (rst) vec_hit |=> in_service;
  endproperty
  vec_busy_chk: assert property (vec_p);
endmodule

bind irq_collector irqc_checker #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .src_in     (src_in),
  .irq_out    (irq_out),
  .gen_en     (gen_en),
  .in_service (in_service),
  .pend       (pend),
  .en_vec     (en_vec),
  .win_valid  (win_valid),
  .win_idx    (win_idx),
  .vec_hit    (vec_hit),
  .ack_hit    (ack_hit)
);

// File: tb/irq_collector_bench.sv
`timescale 1ns/1ps
module irq_collector_bench;
  localparam int NUM_SRC = 64;
  localparam int ADDR_W  = 12;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               bus_wr = 1'b0;
  logic               bus_rd = 1'b0;
  logic [ADDR_W-1:0]  bus_addr = '0;
  logic [31:0]        bus_wdata = '0;
  logic [31:0]        bus_rdata;
  logic [NUM_SRC-1:0] src_in = '0;
  logic               irq_out;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  typedef struct { logic [31:0] val; string tag; } exp_t;
  exp_t exp_q[$];

  irq_collector #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_irq_collector (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_in(src_in), .irq_out(irq_out)
  );

  always #5 clk = ~clk;

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
    exp_t it;
    it.val = e; it.tag = tag;
    @(negedge clk);
    exp_q.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    n_chk++;
    if (irq_out !== e) begin
      n_err++;
      $display("FAIL %s irq_out actual=%0b expected=%0b", tag, irq_out, e);
    end
  endtask

  task automatic pulse(input int s);
    @(negedge clk); src_in[s] = 1'b1;
    @(negedge clk); src_in[s] = 1'b0;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        exp_t it;
        #2;
        n_chk++;
        if (exp_q.size() == 0) begin
          n_err++;
          $display("FAIL scoreboard empty actual=%h expected=none", bus_rdata);
        end else begin
          it = exp_q.pop_front();
          if (bus_rdata !== it.val) begin
            n_err++;
            $display("FAIL %s rdata actual=%h expected=%h", it.tag, bus_rdata, it.val);
          end
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    chk_irq(1'b0, "R1");
    rd_exp(12'h020, 32'h0, "R1 glb");
    rd_exp(12'h100, 32'h0, "R1 cw0");
    rd_exp(12'h130, 32'h0, "R1 cw3");
    rd_exp(12'h030, 32'h0, "R1 status");

    // R2 / R3 aliases and field mask
    wr(12'h100, 32'h0000_0504);
    rd_exp(12'h100, 32'h0000_0504, "R2 plain");
    wr(12'h100, 32'hFFFF_FFFF);
    rd_exp(12'h100, 32'h0707_0707, "R3 mask");
    wr(12'h108, 32'h0404_0404);
    rd_exp(12'h100, 32'h0303_0303, "R2 clear alias");
    wr(12'h104, 32'h0000_0004);
    rd_exp(12'h100, 32'h0303_0307, "R2 set alias");
    wr(12'h10C, 32'h0000_0006);
    rd_exp(12'h100, 32'h0303_0301, "R2 toggle alias");
    wr(12'h100, 32'h0);
    wr(12'h024, 32'h1);
    rd_exp(12'h020, 32'h1, "R2 glb set");
    wr(12'h02C, 32'h1);
    rd_exp(12'h020, 32'h0, "R2 glb toggle");

    // R5/R6: enable sources 5 (word1 field1) and 9 (word2 field1)
    wr(12'h110, 32'h0000_0400);
    wr(12'h120, 32'h0000_0400);
    pulse(9);
    idle(1);
    chk_irq(1'b0, "R7 global off");
    rd_exp(12'h030, 32'h8000_0009, "R5 single");
    wr(12'h024, 32'h1);
    idle(1);
    chk_irq(1'b1, "R6 request");
    pulse(5);
    rd_exp(12'h030, 32'h8000_0005, "R5 lowest wins");
    // R4 clear source 5
    wr(12'h200, 32'h0000_0020);
    rd_exp(12'h030, 32'h8000_0009, "R4 clear drop");
    // R5 masked source 40 ignored
    pulse(40);
    rd_exp(12'h030, 32'h8000_0009, "R5 masked ignored");
    rd_exp(12'h210, 32'h0000_0100, "R4 pending read");
    @(negedge clk); src_in[40] = 1'b1;
    wr(12'h218, 32'h0000_0100);
    rd_exp(12'h210, 32'h0000_0100, "R4 clear while high");
    @(negedge clk); src_in[40] = 1'b0;
    wr(12'h210, 32'h0000_0100);
    rd_exp(12'h210, 32'h0, "R4 clear after low");

    // R8 vector write -> in service
    wr(12'h000, 32'h9);
    idle(1);
    chk_irq(1'b0, "R8 in service");
    rd_exp(12'h000, 32'h9, "R8 vector readback");
    // R9 ack with bit0 clear ignored
    wr(12'h010, 32'h2);
    idle(1);
    chk_irq(1'b0, "R9 ack bit0 clear ignored");
    rd_exp(12'h010, 32'h0, "R9 ack reads zero");
    wr(12'h010, 32'h1);
    idle(1);
    chk_irq(1'b1, "R9 ack releases");
    // R6 masking source 9 drops request
    wr(12'h128, 32'h0000_0400);
    idle(1);
    chk_irq(1'b0, "R6 masked no request");
    wr(12'h124, 32'h0000_0400);
    idle(1);
    chk_irq(1'b1, "R6 unmask request");
    // R7 global disable
    wr(12'h028, 32'h1);
    idle(1);
    chk_irq(1'b0, "R7 global cleared");
    rd_exp(12'h020, 32'h0, "R7 glb reads 0");

    idle(3);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule